// File: doc/BRIEF.md
# Overcurrent Fault Integrator

This block decides when a current-limit episode has gone on long enough, or has come back often enough, to open the electronic circuit breaker. It watches a synchronous overcurrent flag. That flag is high whenever the sense comparator reports that the load current is being regulated at its limit. From the flag the block keeps a running score: every base tick with overcurrent adds one, and a long quiet stretch takes one away. Because the score rises much faster than it falls, two kinds of load trip the breaker. A continuous short trips it, and so does a chain of short overloads whose duty cycle is too high.

When the score reaches the trip count, the block sends a single-cycle trip pulse to the gate controller and clears the score. It then refuses to count again until the controller asserts its breaker-clear input, the same action that restarts the gate after a fault. The base tick is made inside the block by dividing the clock. The defaults give a 1 µs tick at 125 MHz, a trip after 500 overcurrent ticks, and a decay 128 times slower than the climb.

Top module: `ofi_fault_integrator`

Parameters: `TICK_DIV` is the number of clock cycles per base tick (default 125). `TRIP_COUNT` is the number of net overcurrent ticks that trip the breaker (default 500, at least 2). `DECAY_DIV` is the number of consecutive quiet ticks per decrement (default 128, at least 2).

## Requirements
- R1: The block makes one internal base tick every `TICK_DIV` clock cycles, starting from reset release. The inputs are acted on only at base ticks, and `brk_clr` is the one exception.
- R2: At each base tick where `oc_flag` is 1, the score rises by exactly one. After `TRIP_COUNT` consecutive overcurrent ticks from a zero score, `trip` goes to 1 in the clock cycle that follows the edge sampling the last of them.
- R3: The score falls by one only after `DECAY_DIV` consecutive base ticks with `oc_flag` at 0. Any base tick with `oc_flag` at 1 restarts that quiet-tick run from zero.
- R4: Overcurrent on 1 tick followed by `DECAY_DIV` quiet ticks, repeated, never trips. Overcurrent on 1 tick followed by `DECAY_DIV`-1 quiet ticks trips on the `TRIP_COUNT`-th overcurrent tick.
- R5: The score stops at zero. Quiet ticks at zero never make it wrap, so a later trip still needs the full `TRIP_COUNT` overcurrent ticks.
- R6: `trip` stays high for exactly one clock cycle, and the score is zero after it.
- R7: After a trip, no further trip occurs, whatever `oc_flag` does, until `brk_clr` has been asserted. Counting starts again from zero once `brk_clr` is low again.
- R8: While `brk_clr` is 1, the score and the quiet-tick run are held at zero, `oc_flag` is ignored and `trip` stays 0.
- R9: A synchronous reset (`rst_n` low at a clock edge) clears the score, the lockout and the tick phase, and holds `trip` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| oc_flag | input | 1 | Overcurrent flag from the sense comparator, synchronous to clk |
| brk_clr | input | 1 | Breaker clear from the gate controller, active high |
| trip | output | 1 | One-cycle breaker trip pulse to the gate controller |

## Verification
The hardest condition to reach from the ports is the balance point of the integrator. A train of pulses sits right at the ratio where climb and decay cancel, and the result depends on the quiet-tick run restarting on every overcurrent tick. The stimulus holds `oc_flag` in whole tick-length slots, so each slot covers exactly one base tick whatever the tick phase. It then drives one-on and `DECAY_DIV`-off trains, which must never trip, against one-on and one-fewer-off trains, which must trip on a known tick. A further directed case leaves the score one short of the limit and lets exactly one decrement happen before the next overcurrent ticks. Random bursts of varied density, with clears and resets, are compared cycle by cycle with a bench model of the requirements.

// File: rtl/ofi_pkg.sv
// Package: shared types for the overcurrent fault integrator.
// Assumes: nothing beyond IEEE 1800-2017.
package ofi_pkg;

    // Breaker lockout state of the trip counter.
    typedef enum logic {
        OFI_ARMED  = 1'b0,
        OFI_LOCKED = 1'b1
    } ofi_lock_e;

endpackage

// File: rtl/ofi_tick_gen.sv
// Module: ofi_tick_gen
// Divides the clock into a base tick pulse, one cycle wide, every TICK_DIV
// clock cycles. The first tick appears TICK_DIV edges after reset release.
// Assumes: TICK_DIV >= 1; rst_n is synchronous and active low.
module ofi_tick_gen #(
    parameter int TICK_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (TICK_DIV == 1) begin : g_every_cycle
            // Purpose: tick on every clock once out of reset.
            always_ff @(posedge clk) begin
                if (!rst_n) tick <= 1'b0;
                else        tick <= 1'b1;
            end
        end else begin : g_divider
            localparam int DIV_W = $clog2(TICK_DIV);
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

            logic [DIV_W-1:0] phase;

            // Purpose: count clock cycles and pulse tick at the end of each period.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    phase <= '0;
                    tick  <= 1'b0;
                end else if (phase == DIV_LAST) begin
                    phase <= '0;
                    tick  <= 1'b1;
                end else begin
                    phase <= phase + DIV_W'(1);
                    tick  <= 1'b0;
                end
            end

            a_r1_tick_gap : assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ofi_decay_prescaler.sv
// Module: ofi_decay_prescaler
// Counts consecutive quiet base ticks and issues one decay step after every
// DECAY_DIV of them. An overcurrent tick restarts the run; hold flushes it.
// Assumes: DECAY_DIV >= 2; tick is a one-cycle pulse.
module ofi_decay_prescaler #(
    parameter int DECAY_DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic oc,
    input  logic hold,
    output logic dec_step
);

    localparam int PRE_W = $clog2(DECAY_DIV);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DECAY_DIV - 1);

    logic [PRE_W-1:0] quiet_run;

    // Purpose: a decay step is due on the quiet tick that completes a run.
    assign dec_step = tick && !oc && !hold && (quiet_run == PRE_LAST);

    // Purpose: track the length of the current quiet-tick run.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            quiet_run <= '0;
        end else if (tick) begin
            if (oc || quiet_run == PRE_LAST) quiet_run <= '0;
            else                             quiet_run <= quiet_run + PRE_W'(1);
        end
    end

    a_r3_run_restart : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && oc) |=> (quiet_run == '0));

    a_r8_run_flushed : assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (quiet_run == '0));

endmodule

// File: rtl/ofi_trip_counter.sv
// Module: ofi_trip_counter
// Holds the overcurrent score: +1 per overcurrent tick, -1 per decay step,
// floor at zero. On reaching TRIP_COUNT it pulses trip, clears the score and
// locks until clr. While clr is high everything is held at zero.
// Assumes: TRIP_COUNT >= 2; dec_step only arrives on quiet ticks.
module ofi_trip_counter
    import ofi_pkg::*;
#(
    parameter int TRIP_COUNT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic oc,
    input  logic clr,
    input  logic dec_step,
    output logic hold,
    output logic trip
);

    localparam int CNT_W = $clog2(TRIP_COUNT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRIP_COUNT - 1);

    logic [CNT_W-1:0] score;
    ofi_lock_e        lock_q;

    // Purpose: counting is suspended while locked out or being cleared.
    assign hold = (lock_q == OFI_LOCKED) || clr;

    // Purpose: update the score, detect the limit and manage the lockout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            score  <= '0;
            lock_q <= OFI_ARMED;
            trip   <= 1'b0;
        end else begin
            trip <= 1'b0;
            if (clr) begin
                score  <= '0;
                lock_q <= OFI_ARMED;
            end else if (lock_q == OFI_ARMED && tick) begin
                if (oc) begin
                    if (score == CNT_LAST) begin
                        trip   <= 1'b1;
                        score  <= '0;
                        lock_q <= OFI_LOCKED;
                    end else begin
                        score <= score + CNT_W'(1);
                    end
                end else if (dec_step && score != '0) begin
                    score <= score - CNT_W'(1);
                end
            end
        end
    end

    a_r2_step_up : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && oc && !hold && score != CNT_LAST) |=> (score == $past(score) + CNT_W'(1)));

    a_r5_floor : assert property (@(posedge clk) disable iff (!rst_n)
        (score == '0 && !oc) |=> (score == '0));

    a_r6_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (!trip && score == '0));

    a_r7_hold_off : assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q == OFI_LOCKED && !clr) |=> !trip);

    a_r8_clear : assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (score == '0 && lock_q == OFI_ARMED && !trip));

    a_r2_score_bound : assert property (@(posedge clk) disable iff (!rst_n)
        score <= CNT_LAST);

endmodule

// File: rtl/ofi_fault_integrator.sv
// Module: ofi_fault_integrator (top)
// Asymmetric overcurrent fault integrator: divides the clock into base ticks,
// scores overcurrent ticks against slow decay, and pulses trip at the limit.
// Assumes: oc_flag and brk_clr are synchronous to clk; rst_n synchronous.
module ofi_fault_integrator #(
    parameter int TICK_DIV   = 125,
    parameter int TRIP_COUNT = 500,
    parameter int DECAY_DIV  = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag,
    input  logic brk_clr,
    output logic trip
);

    logic tick;
    logic hold;
    logic dec_step;

    ofi_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ofi_decay_prescaler #(.DECAY_DIV(DECAY_DIV)) u_decay (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .oc       (oc_flag),
        .hold     (hold),
        .dec_step (dec_step)
    );

    ofi_trip_counter #(.TRIP_COUNT(TRIP_COUNT)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .oc       (oc_flag),
        .clr      (brk_clr),
        .dec_step (dec_step),
        .hold     (hold),
        .trip     (trip)
    );

    a_r9_reset_quiet : assert property (@(posedge clk)
        !rst_n |=> !trip);

endmodule

// File: tb/tb_ofi_fault_integrator.sv
module tb_ofi_fault_integrator;

    localparam int TD = 3;
    localparam int TC = 12;
    localparam int DD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_flag = 1'b0;
    logic brk_clr = 1'b0;
    logic trip;

    int checks = 0;
    int errors = 0;
    int ph_trips = 0;
    string tag = "R9";

    // reference model state, built from the requirements
    int m_phase = 0;
    bit m_tick = 0;
    int m_score = 0;
    int m_quiet = 0;
    bit m_lock = 0;
    bit m_trip = 0;

    always #4 clk = ~clk;   // 125 MHz

    ofi_fault_integrator #(.TICK_DIV(TD), .TRIP_COUNT(TC), .DECAY_DIV(DD)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .oc_flag (oc_flag),
        .brk_clr (brk_clr),
        .trip    (trip)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge(input bit o, input bit c, input bit r);
        bit t;
        if (!r) begin
            m_phase = 0; m_tick = 0; m_score = 0; m_quiet = 0; m_lock = 0; m_trip = 0;
        end else begin
            t = m_tick;
            m_tick = (m_phase == TD - 1);
            m_phase = (m_phase == TD - 1) ? 0 : m_phase + 1;
            m_trip = 0;
            if (c) begin
                m_score = 0; m_quiet = 0; m_lock = 0;
            end else if (!m_lock && t) begin
                if (o) begin
                    m_quiet = 0;
                    if (m_score + 1 == TC) begin
                        m_trip = 1; m_score = 0; m_lock = 1;
                    end else m_score++;
                end else if (m_quiet == DD - 1) begin
                    m_quiet = 0;
                    if (m_score > 0) m_score--;
                end else m_quiet++;
            end
        end
    endtask

    // one clock: drive at negedge, model at edge, compare at next negedge
    task automatic cyc(input bit o, input bit c, input bit r);
        oc_flag = o; brk_clr = c; rst_n = r;
        @(posedge clk);
        model_edge(o, c, r);
        @(negedge clk);
        if (trip) ph_trips++;
        check(trip === m_trip, tag, int'(trip), int'(m_trip));
    endtask

    task automatic slots(input bit o, input int n);
        for (int i = 0; i < n; i++)
            for (int k = 0; k < TD; k++) cyc(o, 1'b0, 1'b1);
    endtask

    task automatic clear_breaker();
        cyc(1'b0, 1'b1, 1'b1);
        cyc(1'b0, 1'b1, 1'b1);
        ph_trips = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20517));
        @(negedge clk);

        // R9: reset holds trip low
        tag = "R9";
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0);

        // R1, R2: continuous overcurrent trips on the TC-th tick
        tag = "R2";
        clear_breaker();
        slots(1'b1, TC - 1);
        check(ph_trips == 0, "R2 early", ph_trips, 0);
        slots(1'b1, 1);
        check(ph_trips == 1, "R2 R1 at limit", ph_trips, 1);

        // R6, R7: lockout while overcurrent persists
        tag = "R7";
        ph_trips = 0;
        slots(1'b1, 3 * TC);
        check(ph_trips == 0, "R7 lockout", ph_trips, 0);
        clear_breaker();
        slots(1'b1, TC);
        check(ph_trips == 1, "R7 resume", ph_trips, 1);

        // R3: one decrement after DD quiet ticks
        tag = "R3";
        clear_breaker();
        slots(1'b1, TC - 1);
        slots(1'b0, DD);
        slots(1'b1, 1);
        check(ph_trips == 0, "R3 decrement", ph_trips, 0);
        slots(1'b1, 1);
        check(ph_trips == 1, "R3 after decrement", ph_trips, 1);

        // R5: long quiet at zero does not wrap
        tag = "R5";
        clear_breaker();
        slots(1'b0, 20 * DD);
        slots(1'b1, TC - 1);
        check(ph_trips == 0, "R5 floor", ph_trips, 0);
        slots(1'b1, 1);
        check(ph_trips == 1, "R5 full count", ph_trips, 1);

        // R4: balanced train never trips
        tag = "R4";
        clear_breaker();
        for (int p = 0; p < 40; p++) begin
            slots(1'b1, 1);
            slots(1'b0, DD);
        end
        check(ph_trips == 0, "R4 balanced", ph_trips, 0);

        // R4: denser train trips on its TC-th overcurrent tick
        clear_breaker();
        for (int p = 0; p < TC - 1; p++) begin
            slots(1'b1, 1);
            slots(1'b0, DD - 1);
        end
        check(ph_trips == 0, "R4 dense before", ph_trips, 0);
        slots(1'b1, 1);
        check(ph_trips == 1, "R4 dense trip", ph_trips, 1);

        // R8: clear held high ignores overcurrent
        tag = "R8";
        ph_trips = 0;
        for (int i = 0; i < 5 * TC * TD; i++) cyc(1'b1, 1'b1, 1'b1);
        check(ph_trips == 0, "R8 clear held", ph_trips, 0);

        // random bursts of varied density with clears and one reset
        tag = "R1 R3 R7 random";
        for (int b = 0; b < 60; b++) begin
            int dens;
            dens = int'($urandom_range(0, 100));
            for (int s = 0; s < 40; s++) begin
                bit o;
                bit c;
                o = (int'($urandom_range(0, 99)) < dens);
                c = ($urandom_range(0, 59) == 0);
                for (int k = 0; k < TD; k++) cyc(o, c && (k == 0), 1'b1);
            end
            if (b == 30) begin
                tag = "R9 random";
                cyc(1'b1, 1'b0, 1'b0);
                cyc(1'b1, 1'b0, 1'b0);
                tag = "R1 R3 R7 random";
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule